// File: doc/BRIEF.md
# Peripheral Port Region Matcher

This block decides, for every data access leaving address translation, whether the access belongs to a single programmable physical window that is served by the peripheral port. One configuration register holds a page-granular base address and a five-bit logarithmic size code. An access whose address falls inside the window has its memory attribute overridden to non-shared Device and is steered to the peripheral port. This holds whether the attribute came from the page tables, from the default map used with translation off, or from a remap applied earlier in the data stream. With translation off, the untranslated address is presented unchanged on the address input.

The matcher also settles clashes with a tightly-coupled memory. A plain-mode memory keeps the address for itself. A memory in cache mode yields to the window and loses its cache behaviour for that address. Accesses that the port cannot carry, which are unaligned or exclusive ones, raise an error flag and are not forwarded. All access-side outputs are combinational in the same cycle. The register takes effect on the cycle after it is written.

Top module: `ppr_match`

## Requirements
- R1: After reset the register reads 0 and no access is steered to the port.
- R2: A write stores bits [31:12] (base) and [4:0] (size code). Bits [11:5] read as 0. The new value is seen on `cfg_rdata` and used by the compare from the cycle after the write, and the old value is still used during the write cycle.
- R3: Size codes 0, 1, 2 and 23 to 31 disable the window, so no access hits.
- R4: For a size code c from 3 to 22 the window spans 2^(c+9) bytes. A data access hits when address bits [31:c+9] equal the base bits [31:c+9]. Base bits below c+9 are ignored.
- R5: On a hit, `out_attr` is 3'b011 (Device) and `out_shared` is 0, whatever `in_attr`/`in_shared` carry, including an attribute already remapped by the data stream. Otherwise both outputs pass the inputs through. The other inner codes are 000 noncacheable, 001 strongly ordered, 110 write-through and 111 write-back.
- R6: A hit that is also a hit in the tightly-coupled memory in plain mode (`tcm_cache_mode`=0) goes to the memory. In that case `tcm_sel`=1, `port_sel`=0, and the attribute passes through.
- R7: A hit that is also a memory hit in cache mode goes to the port. In that case `port_sel`=1 and `tcm_sel`=0.
- R8: An instruction fetch (`acc_is_data`=0) never hits.
- R9: A valid hit that is unaligned or exclusive sets `port_err`=1 and `port_sel`=0.
- R10: With `acc_valid`=0, the outputs `port_sel`, `port_err` and `tcm_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read value |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Physical (or untranslated) address |
| acc_is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| acc_unaligned | input | 1 | Access is unaligned |
| acc_excl | input | 1 | Access is exclusive |
| in_attr | input | 3 | Incoming inner attribute code |
| in_shared | input | 1 | Incoming shared bit |
| tcm_hit | input | 1 | Address lies in a tightly-coupled memory |
| tcm_cache_mode | input | 1 | That memory runs in cache mode |
| out_attr | output | 3 | Resolved attribute code |
| out_shared | output | 1 | Resolved shared bit |
| port_sel | output | 1 | Forward access to the peripheral port |
| port_err | output | 1 | Port-bound access is unaligned or exclusive |
| tcm_sel | output | 1 | Access is served by the tightly-coupled memory |

## Verification
The assertions check on every cycle the properties that need no address arithmetic. These are: a disabled or zero size code never routes to the port, fetches never route, a plain-mode memory hit always blocks the port, port traffic always carries Device non-shared, error and forward never coincide, and the register reserved bits and write latency behave as required. Only the bench's reference model can show that the window edges are right for each size code and that the ignored base bits are really ignored. The model recomputes the window with shifts over random and boundary-biased addresses and compares the result every cycle. Directed scenarios also check the write-cycle ordering, the overlap cases in both memory modes and the error path.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  localparam int ADDR_W    = 32;
  localparam int PAGE_LSB  = 12;
  localparam int SIZE_W    = 5;
  localparam int CODE_MIN  = 3;
  localparam int CODE_MAX  = 22;
  localparam int CODE_BIAS = 9;
  localparam int ATTR_W    = 3;

  typedef enum logic [ATTR_W-1:0] {
    ATTR_NONCACHE = 3'b000,
    ATTR_STRONG   = 3'b001,
    ATTR_DEVICE   = 3'b011,
    ATTR_WTHRU    = 3'b110,
    ATTR_WBACK    = 3'b111
  } attr_e;

  // Size code is usable only inside the legal band.
  function automatic logic size_code_ok(input logic [SIZE_W-1:0] code);
    return (int'(code) >= CODE_MIN) && (int'(code) <= CODE_MAX);
  endfunction

  // Lowest address bit that takes part in the compare for a code.
  function automatic logic [7:0] cmp_low_bit(input logic [SIZE_W-1:0] code);
    return 8'(code) + 8'(CODE_BIAS);
  endfunction

  // Mask of register bits that hold state.
  function automatic logic [ADDR_W-1:0] cfg_keep_mask();
    logic [ADDR_W-1:0] m;
    m = '0;
    for (int i = 0; i < ADDR_W; i++)
      m[i] = (i >= PAGE_LSB) || (i < SIZE_W);
    return m;
  endfunction
endpackage

// File: rtl/ppr_cfg_reg.sv
module ppr_cfg_reg
  import ppr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PL = PAGE_LSB,
  parameter int SW = SIZE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:PL] base_q,
  output logic [SW-1:0] size_q,
  output logic [AW-1:0] rdata
);
  localparam int GAP_W = PL - SW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
    end else if (wr_en) begin
      base_q <= wdata[AW-1:PL];
      size_q <= wdata[SW-1:0];
    end
  end

  assign rdata = {base_q, {GAP_W{1'b0}}, size_q};
endmodule

// File: rtl/ppr_addr_cmp.sv
module ppr_addr_cmp
  import ppr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PL = PAGE_LSB,
  parameter int SW = SIZE_W
) (
  input  logic [AW-1:PL] base,
  input  logic [SW-1:0]  size,
  input  logic [AW-1:0]  addr,
  input  logic           is_data,
  output logic           size_ok,
  output logic           region_hit
);
  logic [7:0]     low_bit;
  logic [AW-1:PL] bit_used;
  logic [AW-1:PL] bit_diff;

  assign low_bit = cmp_low_bit(size);
  assign size_ok = size_code_ok(size);

  for (genvar i = PL; i < AW; i++) begin : g_bit
    assign bit_used[i] = (8'(i) >= low_bit);
    assign bit_diff[i] = bit_used[i] & (addr[i] ^ base[i]);
  end

  assign region_hit = size_ok & is_data & ~(|bit_diff);
endmodule

// File: rtl/ppr_resolve.sv
module ppr_resolve
  import ppr_pkg::*;
(
  input  logic              region_hit,
  input  logic              acc_valid,
  input  logic              acc_unaligned,
  input  logic              acc_excl,
  input  logic [ATTR_W-1:0] in_attr,
  input  logic              in_shared,
  input  logic              tcm_hit,
  input  logic              tcm_cache_mode,
  output logic              win_hit,
  output logic              tcm_claims,
  output logic [ATTR_W-1:0] out_attr,
  output logic              out_shared,
  output logic              port_sel,
  output logic              port_err,
  output logic              tcm_sel
);
  logic bad_kind;

  // A plain-mode memory keeps overlapping addresses; cache mode yields.
  assign tcm_claims = tcm_hit & ~tcm_cache_mode;
  assign win_hit    = region_hit & ~tcm_claims;
  assign bad_kind   = acc_unaligned | acc_excl;

  always_comb begin
    out_attr   = in_attr;
    out_shared = in_shared;
    if (win_hit) begin
      out_attr   = ATTR_DEVICE;
      out_shared = 1'b0;
    end
  end

  assign port_sel = acc_valid & win_hit & ~bad_kind;
  assign port_err = acc_valid & win_hit & bad_kind;
  assign tcm_sel  = acc_valid & tcm_hit & ~win_hit;
endmodule

// File: rtl/ppr_match.sv
module ppr_match
  import ppr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PL = PAGE_LSB,
  parameter int SW = SIZE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [AW-1:0]     cfg_rdata,
  input  logic              acc_valid,
  input  logic [AW-1:0]     acc_addr,
  input  logic              acc_is_data,
  input  logic              acc_unaligned,
  input  logic              acc_excl,
  input  logic [ATTR_W-1:0] in_attr,
  input  logic              in_shared,
  input  logic              tcm_hit,
  input  logic              tcm_cache_mode,
  output logic [ATTR_W-1:0] out_attr,
  output logic              out_shared,
  output logic              port_sel,
  output logic              port_err,
  output logic              tcm_sel
);
  logic [AW-1:PL] base_q;
  logic [SW-1:0]  size_q;
  logic           size_ok;
  logic           region_hit;
  logic           win_hit;
  logic           tcm_claims;

  ppr_cfg_reg #(.AW(AW), .PL(PL), .SW(SW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wdata(cfg_wdata),
    .base_q(base_q), .size_q(size_q), .rdata(cfg_rdata)
  );

  ppr_addr_cmp #(.AW(AW), .PL(PL), .SW(SW)) u_cmp (
    .base(base_q), .size(size_q), .addr(acc_addr), .is_data(acc_is_data),
    .size_ok(size_ok), .region_hit(region_hit)
  );

  ppr_resolve u_res (
    .region_hit(region_hit), .acc_valid(acc_valid),
    .acc_unaligned(acc_unaligned), .acc_excl(acc_excl),
    .in_attr(in_attr), .in_shared(in_shared),
    .tcm_hit(tcm_hit), .tcm_cache_mode(tcm_cache_mode),
    .win_hit(win_hit), .tcm_claims(tcm_claims),
    .out_attr(out_attr), .out_shared(out_shared),
    .port_sel(port_sel), .port_err(port_err), .tcm_sel(tcm_sel)
  );
endmodule

// File: rtl/ppr_match_chk.sv
module ppr_match_chk
  import ppr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [AW-1:0]     cfg_wdata,
  input logic [AW-1:0]     cfg_rdata,
  input logic              acc_valid,
  input logic              acc_is_data,
  input logic              acc_unaligned,
  input logic              acc_excl,
  input logic              tcm_hit,
  input logic              tcm_cache_mode,
  input logic [ATTR_W-1:0] out_attr,
  input logic              out_shared,
  input logic              port_sel,
  input logic              port_err,
  input logic              tcm_sel,
  input logic              region_hit,
  input logic              size_ok
);
  localparam logic [AW-1:0] KEEP = cfg_keep_mask();

  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (cfg_rdata == '0));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~KEEP) == '0);

  a_r2_write_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> (cfg_rdata == ($past(cfg_wdata) & KEEP)));

  a_r3_disabled_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !size_ok |-> (!region_hit && !port_sel && !port_err));

  a_r5_port_is_device: assert property (@(posedge clk) disable iff (!rst_n)
    (port_sel || port_err) |-> (out_attr == ATTR_DEVICE && !out_shared));

  a_r6_plain_tcm_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && tcm_hit && !tcm_cache_mode) |-> (tcm_sel && !port_sel && !port_err));

  a_r7_route_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tcm_sel && (port_sel || port_err)));

  a_r8_fetch_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_is_data |-> (!region_hit && !port_sel && !port_err));

  a_r9_err_only_bad: assert property (@(posedge clk) disable iff (!rst_n)
    port_err |-> ((acc_unaligned || acc_excl) && !port_sel));

  a_r9_fwd_only_good: assert property (@(posedge clk) disable iff (!rst_n)
    port_sel |-> (!acc_unaligned && !acc_excl));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!port_sel && !port_err && !tcm_sel));
endmodule

bind ppr_match ppr_match_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .acc_valid(acc_valid), .acc_is_data(acc_is_data),
  .acc_unaligned(acc_unaligned), .acc_excl(acc_excl), .tcm_hit(tcm_hit),
  .tcm_cache_mode(tcm_cache_mode), .out_attr(out_attr), .out_shared(out_shared),
  .port_sel(port_sel), .port_err(port_err), .tcm_sel(tcm_sel),
  .region_hit(region_hit), .size_ok(size_ok)
);

// File: tb/ppr_match_tb.sv
`timescale 1ns/1ps
module ppr_match_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_is_data = 1'b1;
  logic        acc_unaligned = 1'b0;
  logic        acc_excl = 1'b0;
  logic [2:0]  in_attr = 3'b111;
  logic        in_shared = 1'b1;
  logic        tcm_hit = 1'b0;
  logic        tcm_cache_mode = 1'b0;
  logic [2:0]  out_attr;
  logic        out_shared, port_sel, port_err, tcm_sel;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] m_reg = '0;

  always #2.5 clk = ~clk;

  ppr_match dut_i (.*);

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Reference: window test by shifting both values down by the region order.
  function automatic bit m_region(input logic [31:0] r, input logic [31:0] a, input bit is_d);
    int c;
    int sh;
    c = int'(r[4:0]);
    if (!is_d || c < 3 || c > 22) return 1'b0;
    sh = c + 9;
    return (a >> sh) == (r >> sh);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_reg <= '0;
    else if (cfg_wr_en) m_reg <= {cfg_wdata[31:12], 7'd0, cfg_wdata[4:0]};
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit rh, wh, bad;
      rh  = m_region(m_reg, acc_addr, acc_is_data);
      wh  = rh && !(tcm_hit && !tcm_cache_mode);
      bad = acc_unaligned || acc_excl;
      chk("R2", "rdata", cfg_rdata, m_reg);
      chk("R5", "attr", {28'd0, out_attr, out_shared}, wh ? 32'h6 : {28'd0, in_attr, in_shared});
      chk("R4", "port_sel", 32'(port_sel), 32'(acc_valid && wh && !bad));
      chk("R9", "port_err", 32'(port_err), 32'(acc_valid && wh && bad));
      chk("R6", "tcm_sel", 32'(tcm_sel), 32'(acc_valid && tcm_hit && !wh));
    end
  end

  task automatic wr(input logic [31:0] d);
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_wdata = d; acc_valid = 1'b0;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
  endtask

  task automatic acc(input logic [31:0] a, input bit d, input bit th, input bit tc,
                     input bit un, input bit ex);
    @(posedge clk); #1;
    acc_valid = 1'b1; acc_addr = a; acc_is_data = d; tcm_hit = th;
    tcm_cache_mode = tc; acc_unaligned = un; acc_excl = ex;
    #1;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rdata in reset", cfg_rdata, 32'h0);
    rst_n = 1'b1;
    acc(32'h0, 1, 0, 0, 0, 0);
    chk("R1", "no hit after reset", 32'(port_sel), 32'h0);

    wr(32'h4000_0FE3);
    chk("R2", "reserved bits read zero", cfg_rdata, 32'h4000_0003);
    acc(32'h4000_0ABC, 1, 0, 0, 0, 0);
    chk("R4", "4KB inside", 32'(port_sel), 32'h1);
    chk("R5", "forced device", 32'(out_attr), 32'h3);
    chk("R5", "forced non-shared", 32'(out_shared), 32'h0);
    acc(32'h4000_1000, 1, 0, 0, 0, 0);
    chk("R4", "4KB just above", 32'(port_sel), 32'h0);
    chk("R5", "passthrough attr", 32'(out_attr), 32'h7);

    wr(32'h4000_5005);
    acc(32'h4000_4004, 1, 0, 0, 0, 0);
    chk("R4", "16KB low base bits ignored", 32'(port_sel), 32'h1);
    acc(32'h4000_8000, 1, 0, 0, 0, 0);
    chk("R4", "16KB above", 32'(port_sel), 32'h0);
    acc(32'h4000_3FFF, 1, 0, 0, 0, 0);
    chk("R4", "16KB below", 32'(port_sel), 32'h0);

    acc(32'h4000_4004, 0, 0, 0, 0, 0);
    chk("R8", "fetch no hit", 32'(port_sel), 32'h0);
    chk("R8", "fetch attr pass", 32'(out_attr), 32'h7);

    acc(32'h4000_4004, 1, 1, 0, 0, 0);
    chk("R6", "plain tcm wins port", 32'(port_sel), 32'h0);
    chk("R6", "plain tcm selected", 32'(tcm_sel), 32'h1);
    chk("R6", "plain tcm attr pass", 32'(out_attr), 32'h7);
    acc(32'h4000_4004, 1, 1, 1, 0, 0);
    chk("R7", "cache tcm yields", 32'(port_sel), 32'h1);
    chk("R7", "cache tcm not selected", 32'(tcm_sel), 32'h0);

    acc(32'h4000_4001, 1, 0, 0, 1, 0);
    chk("R9", "unaligned err", 32'(port_err), 32'h1);
    chk("R9", "unaligned not forwarded", 32'(port_sel), 32'h0);
    acc(32'h4000_4000, 1, 0, 0, 0, 1);
    chk("R9", "exclusive err", 32'(port_err), 32'h1);

    @(posedge clk); #1;
    acc_valid = 1'b0; acc_unaligned = 1'b1; tcm_hit = 1'b1; #1;
    chk("R10", "idle quiet", {29'd0, port_sel, port_err, tcm_sel}, 32'h0);
    acc_unaligned = 1'b0; tcm_hit = 1'b0;

    wr(32'h4000_4002);
    acc(32'h4000_4000, 1, 0, 0, 0, 0);
    chk("R3", "code 2 disabled", 32'(port_sel), 32'h0);
    wr(32'h4000_4017);
    acc(32'h4000_4000, 1, 0, 0, 0, 0);
    chk("R3", "code 23 disabled", 32'(port_sel), 32'h0);
    wr(32'h4000_4000);
    acc(32'h4000_4000, 1, 0, 0, 0, 0);
    chk("R3", "code 0 disabled", 32'(port_sel), 32'h0);

    wr(32'h8000_0016);
    acc(32'hFFFF_FFFC, 1, 0, 0, 0, 0);
    chk("R4", "2GB top", 32'(port_sel), 32'h1);
    acc(32'h7FFF_FFFC, 1, 0, 0, 0, 0);
    chk("R4", "2GB below", 32'(port_sel), 32'h0);

    // Write cycle still uses the old window.
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_wdata = 32'h1234_5003;
    acc_valid = 1'b1; acc_addr = 32'h1234_5010; acc_is_data = 1'b1; #1;
    chk("R2", "old value during write", 32'(port_sel), 32'h0);
    @(posedge clk); #1;
    cfg_wr_en = 1'b0; #1;
    chk("R2", "new value after write", 32'(port_sel), 32'h1);

    for (int n = 0; n < 4000; n++) begin
      @(posedge clk); #1;
      cfg_wr_en = ($urandom_range(15) == 0);
      cfg_wdata = $urandom;
      if ($urandom_range(3) != 0) cfg_wdata[4:0] = 5'($urandom_range(22, 3));
      acc_valid = ($urandom_range(7) != 0);
      acc_addr = $urandom_range(1) ? (m_reg ^ ($urandom >> $urandom_range(31, 8))) : $urandom;
      acc_is_data = ($urandom_range(5) != 0);
      acc_unaligned = ($urandom_range(7) == 0);
      acc_excl = ($urandom_range(7) == 0);
      in_attr = 3'($urandom);
      in_shared = 1'($urandom);
      tcm_hit = ($urandom_range(3) == 0);
      tcm_cache_mode = 1'($urandom);
    end

    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule